// File: doc/BRIEF.md
# Sticky FIFO Event Status Word

This block watches the fill levels of a transmit FIFO and a receive FIFO in a serial bus controller. It turns what it sees into a read-only 32-bit status word. Every time a FIFO becomes empty, becomes full or sits exactly at its programmed threshold, a flag latches. The flag then holds until software reads the word, so a brief condition that is already gone by the time of the read is still reported.

Pointer errors follow a different rule. A write into a full FIFO or a read from an empty one arrives as a one-cycle pulse, and the flag it sets ignores reads. Only a soft reset of that direction clears it. A single enable input gates the whole word: while the FIFOs are disabled the word reads zero and no events collect.

The FIFOs, the bus protocol engine and the host decode are outside the block. They appear here only as counts, thresholds, pulses and a read strobe.

Top module: `fifo_event_status`

## Requirements
- R1: Bits 31 to 8 of `status_word` are always zero. The low byte is laid out, from bit 7 down to bit 0, as: RX pointer error, TX pointer error, RX threshold, RX full, RX empty, TX threshold, TX full, TX empty.
- R2: After a synchronous reset (`rst` high at a clock edge), `status_word` is 0x00000000.
- R3: While `fifo_en` is low, `status_word` is zero, no flag collects, and all flags are held cleared. When `fifo_en` rises, the word starts from zero.
- R4: At a clock edge with the enable high, a count of zero sets that direction's empty flag (bit 0 for TX, bit 3 for RX). The flag stays set on later cycles until a read clears it.
- R5: At a clock edge with the enable high, a count equal to the FIFO depth (`DEPTH`, default 16) sets that direction's full flag (bit 1 for TX, bit 4 for RX). The flag is sticky until a read.
- R6: At a clock edge with the enable high, a count equal to that direction's threshold input sets its threshold flag (bit 2 for TX, bit 5 for RX). The flag is sticky until a read.
- R7: The word shows the pre-clear flags during the cycle in which `rd_stb` is high. After that edge, the empty, full and threshold flags are clear, except where their condition is true at that same edge. Such a flag stays set.
- R8: A one-cycle `tx_ptr_err` or `rx_ptr_err` pulse sets bit 6 or bit 7 respectively. Reads do not clear these bits.
- R9: A `tx_soft_rst` or `rx_soft_rst` pulse clears every flag of that direction only. A pointer-error pulse in the same cycle is discarded, while a level condition true at that edge still sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO enable; zero blanks and clears the word |
| rd_stb | input | 1 | One-cycle read strobe for the status word |
| tx_count | input | CW | Entries held in the transmit FIFO |
| rx_count | input | CW | Unread entries in the receive FIFO |
| tx_thresh | input | CW | Transmit threshold value |
| rx_thresh | input | CW | Receive threshold value |
| tx_ptr_err | input | 1 | Transmit pointer error pulse |
| rx_ptr_err | input | 1 | Receive pointer error pulse |
| tx_soft_rst | input | 1 | Transmit direction reset pulse |
| rx_soft_rst | input | 1 | Receive direction reset pulse |
| status_word | output | 32 | Sticky status word |

(CW = $clog2(DEPTH+1), 5 by default.)

## Verification
Every flag is a register that the word shows directly, so any wrong internal state appears at `status_word` one clock after the edge that stored it. It stays visible until the next read or direction reset. If a flag fails to clear, the wrong bit shows in the cycle after the read. If a pointer error is lost, the bit is missing one cycle after the pulse and stays missing through every later read, until a soft reset of that direction. A behavioural model of the sticky rules, compared on every cycle across directed sequences and long random stimulus, reports such divergences the cycle they occur.

// File: rtl/fifo_event_status_pkg.sv
package fifo_event_status_pkg;

    localparam int STATUS_W = 32;
    localparam int FLAG_W   = 8;
    localparam int NUM_DIR  = 2;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dir_e;

    // Level conditions seen on the count this cycle
    typedef struct packed {
        logic at_thresh;
        logic is_full;
        logic is_empty;
    } level_evt_t;

    // Latched flags of one direction
    typedef struct packed {
        logic ptr_err;
        logic at_thresh;
        logic is_full;
        logic is_empty;
    } dir_flags_t;

    // Bit order is what software decodes: 7..0 = rxPE txPE rxTH rxFU rxEM txTH txFU txEM
    function automatic logic [FLAG_W-1:0] pack_flags(input dir_flags_t tx, input dir_flags_t rx);
        return {rx.ptr_err, tx.ptr_err,
                rx.at_thresh, rx.is_full, rx.is_empty,
                tx.at_thresh, tx.is_full, tx.is_empty};
    endfunction

    function automatic level_evt_t sticky_merge(input level_evt_t held, input logic clr,
                                                input level_evt_t now);
        level_evt_t kept;
        kept = clr ? '0 : held;
        return kept | now;
    endfunction

endpackage

// File: rtl/fifo_level_detect.sv
module fifo_level_detect
    import fifo_event_status_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] thresh,
    output level_evt_t    evt
);
    localparam logic [CW-1:0] FULL_COUNT = CW'(DEPTH);

    always_comb begin
        evt.is_empty  = (count == '0);
        evt.is_full   = (count == FULL_COUNT);
        evt.at_thresh = (count == thresh);
    end
endmodule

// File: rtl/dir_flag_bank.sv
module dir_flag_bank
    import fifo_event_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       rd_stb,
    input  logic       soft_rst,
    input  logic       ptr_err,
    input  level_evt_t evt,
    output dir_flags_t flags
);
    level_evt_t lvl_q, lvl_d;
    logic       perr_q, perr_d;

    always_comb begin
        lvl_d  = sticky_merge(lvl_q, rd_stb | soft_rst, evt);
        perr_d = soft_rst ? 1'b0 : (perr_q | ptr_err);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            lvl_q  <= '0;
            perr_q <= 1'b0;
        end else begin
            lvl_q  <= lvl_d;
            perr_q <= perr_d;
        end
    end

    assign flags.ptr_err   = perr_q;
    assign flags.at_thresh = lvl_q.at_thresh;
    assign flags.is_full   = lvl_q.is_full;
    assign flags.is_empty  = lvl_q.is_empty;

    a_r4_empty_latches: assert property (@(posedge clk) disable iff (rst)
        enable && evt.is_empty |=> flags.is_empty);
    a_r5_full_latches: assert property (@(posedge clk) disable iff (rst)
        enable && evt.is_full |=> flags.is_full);
    a_r6_thresh_latches: assert property (@(posedge clk) disable iff (rst)
        enable && evt.at_thresh |=> flags.at_thresh);
    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
        rd_stb && !evt.is_empty |=> !flags.is_empty);
    a_r8_perr_sticky: assert property (@(posedge clk) disable iff (rst)
        enable && flags.ptr_err && !soft_rst |=> flags.ptr_err);
    a_r9_soft_clears: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !flags.ptr_err);
endmodule

// File: rtl/status_word_pack.sv
module status_word_pack
    import fifo_event_status_pkg::*;
(
    input  logic                enable,
    input  dir_flags_t          tx_flags,
    input  dir_flags_t          rx_flags,
    output logic [STATUS_W-1:0] word
);
    localparam int PAD_W = STATUS_W - FLAG_W;

    always_comb begin
        word = '0;
        if (enable) word = {{PAD_W{1'b0}}, pack_flags(tx_flags, rx_flags)};
    end
endmodule

// File: rtl/fifo_event_status.sv
module fifo_event_status
    import fifo_event_status_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en,
    input  logic          rd_stb,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_thresh,
    input  logic [CW-1:0] rx_thresh,
    input  logic          tx_ptr_err,
    input  logic          rx_ptr_err,
    input  logic          tx_soft_rst,
    input  logic          rx_soft_rst,
    output logic [31:0]   status_word
);
    logic [CW-1:0] cnt_a    [NUM_DIR];
    logic [CW-1:0] thr_a    [NUM_DIR];
    logic          perr_a   [NUM_DIR];
    logic          srst_a   [NUM_DIR];
    level_evt_t    evt_a    [NUM_DIR];
    dir_flags_t    flags_a  [NUM_DIR];

    assign cnt_a[DIR_TX]  = tx_count;
    assign cnt_a[DIR_RX]  = rx_count;
    assign thr_a[DIR_TX]  = tx_thresh;
    assign thr_a[DIR_RX]  = rx_thresh;
    assign perr_a[DIR_TX] = tx_ptr_err;
    assign perr_a[DIR_RX] = rx_ptr_err;
    assign srst_a[DIR_TX] = tx_soft_rst;
    assign srst_a[DIR_RX] = rx_soft_rst;

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        fifo_level_detect #(.DEPTH(DEPTH), .CW(CW)) det_i (
            .count  (cnt_a[d]),
            .thresh (thr_a[d]),
            .evt    (evt_a[d])
        );
        dir_flag_bank bank_i (
            .clk      (clk),
            .rst      (rst),
            .enable   (fifo_en),
            .rd_stb   (rd_stb),
            .soft_rst (srst_a[d]),
            .ptr_err  (perr_a[d]),
            .evt      (evt_a[d]),
            .flags    (flags_a[d])
        );
    end

    status_word_pack pack_i (
        .enable   (fifo_en),
        .tx_flags (flags_a[DIR_TX]),
        .rx_flags (flags_a[DIR_RX]),
        .word     (status_word)
    );

    a_r3_disable_clean: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |=> status_word == 32'h0);
    a_r2_reset_zero: assert property (@(posedge clk)
        rst |=> status_word == 32'h0);
endmodule

// File: tb/fifo_event_status_tb_top.sv
module fifo_event_status_tb_top;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst, fifo_en, rd_stb;
    logic [CW-1:0] tx_count, rx_count, tx_thresh, rx_thresh;
    logic tx_ptr_err, rx_ptr_err, tx_soft_rst, rx_soft_rst;
    logic [31:0] status_word;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // behavioural model: index 0 = tx, 1 = rx
    int m_emp[2], m_full[2], m_thr[2], m_perr[2];

    always #10 clk = ~clk;

    fifo_event_status #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .rd_stb(rd_stb),
        .tx_count(tx_count), .rx_count(rx_count),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
        .tx_ptr_err(tx_ptr_err), .rx_ptr_err(rx_ptr_err),
        .tx_soft_rst(tx_soft_rst), .rx_soft_rst(rx_soft_rst),
        .status_word(status_word)
    );

    function automatic logic [31:0] model_word();
        logic [31:0] w;
        w = 32'h0;
        if (fifo_en) begin
            w[7] = m_perr[1] != 0; w[6] = m_perr[0] != 0;
            w[5] = m_thr[1]  != 0; w[4] = m_full[1] != 0; w[3] = m_emp[1] != 0;
            w[2] = m_thr[0]  != 0; w[1] = m_full[0] != 0; w[0] = m_emp[0] != 0;
        end
        return w;
    endfunction

    task automatic model_step();
        int cnt, thr, perr, srst;
        for (int d = 0; d < 2; d++) begin
            cnt  = (d == 0) ? int'(tx_count)  : int'(rx_count);
            thr  = (d == 0) ? int'(tx_thresh) : int'(rx_thresh);
            perr = (d == 0) ? int'(tx_ptr_err) : int'(rx_ptr_err);
            srst = (d == 0) ? int'(tx_soft_rst) : int'(rx_soft_rst);
            if (rst || !fifo_en) begin
                m_emp[d] = 0; m_full[d] = 0; m_thr[d] = 0; m_perr[d] = 0;
            end else begin
                if (rd_stb || srst != 0) begin
                    m_emp[d] = 0; m_full[d] = 0; m_thr[d] = 0;
                end
                if (cnt == 0)     m_emp[d]  = 1;
                if (cnt == DEPTH) m_full[d] = 1;
                if (cnt == thr)   m_thr[d]  = 1;
                if (srst != 0)      m_perr[d] = 0;
                else if (perr != 0) m_perr[d] = 1;
            end
        end
    endtask

    function automatic string bit_req(int b);
        if (b >= 8) return "R1";
        if (b >= 6) return "R8";
        if (b == 0 || b == 3) return "R4";
        if (b == 1 || b == 4) return "R5";
        return "R6";
    endfunction

    task automatic compare_model();
        logic [31:0] exp;
        exp = model_word();
        tests++;
        if (status_word !== exp) begin
            fails++;
            if (!fifo_en)
                $display("FAIL R3 model: got %h expected %h", status_word, exp);
            else
                for (int b = 31; b >= 0; b--)
                    if (status_word[b] !== exp[b]) begin
                        $display("FAIL %s model bit %0d: got %h expected %h",
                                 bit_req(b), b, status_word, exp);
                        break;
                    end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_model();
    endtask

    task automatic chk(string req, logic [31:0] exp);
        tests++;
        if (status_word !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, status_word, exp);
        end
    endtask

    task automatic quiet();
        rd_stb = 0; tx_ptr_err = 0; rx_ptr_err = 0; tx_soft_rst = 0; rx_soft_rst = 0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int d = 0; d < 2; d++) begin m_emp[d]=0; m_full[d]=0; m_thr[d]=0; m_perr[d]=0; end
        rst = 1; fifo_en = 0; quiet();
        tx_count = 0; rx_count = 0; tx_thresh = 4; rx_thresh = 8;
        @(negedge clk);
        tick(); tick();
        chk("R2 reset value", 32'h0);
        rst = 0;
        tick();
        chk("R3 disabled with empty FIFOs", 32'h0);
        fifo_en = 1; tx_count = 3; rx_count = 3;
        tick();
        chk("R3 enable starts clean", 32'h0);
        tx_count = 0; tick();
        chk("R4 tx empty sets", 32'h1);
        tx_count = 3; tick();
        chk("R4 tx empty sticky", 32'h1);
        rd_stb = 1;
        chk("R7 read sees pre-clear value", 32'h1);
        tick(); rd_stb = 0;
        chk("R7 read clears", 32'h0);
        tx_count = 0; tick();
        rd_stb = 1; tick(); rd_stb = 0;
        chk("R7 condition during read re-sets", 32'h1);
        tx_count = 3; rd_stb = 1; tick(); rd_stb = 0;
        rx_count = 16; tick();
        chk("R5 rx full", 32'h10);
        rx_count = 8; tick();
        chk("R6 rx threshold", 32'h30);
        rx_count = 3; rd_stb = 1; tick(); rd_stb = 0;
        tx_count = 4; tick();
        chk("R6 tx threshold", 32'h04);
        tx_count = 3; rd_stb = 1; tick(); rd_stb = 0;
        rx_ptr_err = 1; tick(); rx_ptr_err = 0;
        chk("R8 rx pointer error", 32'h80);
        rd_stb = 1; tick(); rd_stb = 0;
        chk("R8 pointer error survives read", 32'h80);
        tx_ptr_err = 1; tick(); tx_ptr_err = 0;
        chk("R8 tx pointer error", 32'hC0);
        rx_soft_rst = 1; tick(); rx_soft_rst = 0;
        chk("R9 rx reset clears rx only", 32'h40);
        tx_soft_rst = 1; tx_ptr_err = 1; tick(); quiet();
        chk("R9 reset wins over same-cycle error", 32'h0);
        fifo_en = 0; rx_ptr_err = 1; tick(); quiet();
        fifo_en = 1; tick();
        chk("R3 no collection while disabled", 32'h0);

        // random phase, R1 checked every cycle by the model compare
        for (int i = 0; i < 4000; i++) begin
            tx_count    = CW'($urandom_range(0, DEPTH));
            rx_count    = CW'($urandom_range(0, DEPTH));
            if ($urandom_range(0, 31) == 0) tx_thresh = CW'($urandom_range(0, DEPTH));
            if ($urandom_range(0, 31) == 0) rx_thresh = CW'($urandom_range(0, DEPTH));
            rd_stb      = ($urandom_range(0, 3) == 0);
            tx_ptr_err  = ($urandom_range(0, 15) == 0);
            rx_ptr_err  = ($urandom_range(0, 15) == 0);
            tx_soft_rst = ($urandom_range(0, 31) == 0);
            rx_soft_rst = ($urandom_range(0, 31) == 0);
            fifo_en     = ($urandom_range(0, 63) != 0);
            rst         = ($urandom_range(0, 511) == 0);
            tick();
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule